// File: doc/BRIEF.md
# Clock Lock Status and Owner Event Notifier

This block keeps the lock state and error history of eleven external sample-clock inputs. It also holds the small set of global control words that a host uses to claim the device and to steer the sample clock. A host first claims ownership by swapping its own 64-bit notification address into the owner word with a compare-and-swap. From then on, each qualifying event makes the block latch a new event mask. The mask is also issued as a one-cycle write request aimed at that address.

The qualifying events are:
- a lock change on any input;
- a lock change of the input that is currently selected;
- an accepted write to the clock-select word;
- a configuration-change pulse from either stream direction.

Slip (error) flags are kept apart from the live lock flags. Each slip flag holds from the first error until the host reads the status word with a single-word read. A slip never raises a notification. A bus reset drops ownership and stops streaming.

Register access uses a one-request-per-cycle port with read, write and compare-swap operations. The response appears on the cycle after the request.

Top module: `clk_event_notifier`

## Requirements
- R1: After reset the owner word reads 0xFFFF_0000_0000_0000 (no owner), the event word reads 0, the stream enable is off, and clock select is source 12 (internal) with rate code 2. No notification and no response are issued.
- R2: Register addresses are 0 owner, 1 event word, 2 clock select, 3 stream enable, 4 extended status. Operation codes are 0 read, 1 write, 2 compare-swap. The owner word changes only through a compare-swap at address 0 whose compare value equals the current owner. A compare-swap returns the old owner value, with ok=1 only on a match. A plain write to address 0 is refused (ok=0) and changes nothing.
- R3: A bus reset returns the owner word to the no-owner value and clears the stream enable on the next cycle. In that same cycle it overrides any compare-swap or enable write, and such a request returns ok=0.
- R4: A change in any live lock input sets event bit 6. The new mask fully replaces the earlier event word, and the notification appears one cycle after the input change.
- R5: Event bit 4 is set when the lock of the currently selected source changes. Sources 0–3 map to lock bits 0–3, source 4 to any of bits 0–3, source 5 to bit 4, source 6 to bit 5, source 7 to bit 10, sources 8–11 to bits 6–9, and source 12 (internal) never changes.
- R6: A clock-select write carries the source in bits 7:0 and the rate in bits 15:8. It is accepted only if source ≤ 12 and rate ≤ 6. An accepted write updates the clock outputs, returns ok=1 and raises event bit 5. A rejected write changes nothing, returns ok=0 and raises no event.
- R7: Slip flags are sticky and raise no event. A single-word read of the extended status clears them, but a block read does not. The clearing read returns the value before clearing, and a slip arriving in the same cycle as the clearing read stays set.
- R8: While the owner word holds the no-owner value, no notification write is issued, but the event word is still updated.
- R9: Events that coincide in one cycle are merged into a single notification write whose data is the OR of their bits.
- R10: The stream enable is on after a nonzero write to address 3 and off after a zero write.
- R11: The extended status word holds the lock flags in bits 0–10 and the slip flags in bits 16–26. The order is four serial digital-audio inputs, then the optical multichannel input, the parallel digital input, four receive-stream inputs, and word clock.
- R12: A receive or transmit configuration-change pulse raises event bit 0 or bit 1 respectively.
- R13: A notification write carries the owner address, as it stood in the event cycle, together with the new mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_reset_i | input | 1 | Bus reset pulse |
| req_valid_i | input | 1 | Register request present |
| req_op_i | input | 2 | 0 read, 1 write, 2 compare-swap |
| req_addr_i | input | 3 | Register address |
| req_block_i | input | 1 | Request is part of a block read |
| req_wdata_i | input | 64 | Write or swap data |
| req_cmp_i | input | 64 | Compare value for compare-swap |
| rsp_valid_o | output | 1 | Response present, one cycle after request |
| rsp_ok_o | output | 1 | Request accepted |
| rsp_rdata_o | output | 64 | Read data, or old owner for compare-swap |
| lock_i | input | 11 | Live lock flag per clock input |
| slip_i | input | 11 | Slip error pulse per clock input |
| rx_cfg_chg_i | input | 1 | Receive configuration changed pulse |
| tx_cfg_chg_i | input | 1 | Transmit configuration changed pulse |
| ntf_valid_o | output | 1 | Notification write request |
| ntf_addr_o | output | 64 | Notification destination (owner) |
| ntf_data_o | output | 32 | Notification event mask |
| stream_en_o | output | 1 | Streaming enabled |
| clk_source_o | output | 8 | Selected clock source |
| clk_rate_o | output | 8 | Selected rate code |

## Verification
A wrong lock reference would show within one cycle as a missing or spurious notification, or as the wrong bit 4/bit 6 pattern in its data. A slip register that clears too early or too late is seen on the very next single-word status read. An owner word corrupted by a plain write or by a missed bus reset shows up right away in compare-swap responses and in the address or suppression of the next notification. Merging faults appear as two pulses or a partial mask where one combined write is due.

// File: rtl/cksn_pkg.sv
// Shared constants, register map and source-to-lock mapping for the
// clock event notifier. Assumes eleven clock inputs in a fixed order.
package cksn_pkg;
    localparam int NSRC      = 11;
    localparam int LOCK_LSB  = 0;
    localparam int SLIP_LSB  = 16;
    localparam int DW        = 32;
    localparam int AW        = 64;

    localparam logic [AW-1:0] NO_OWNER = 64'hFFFF_0000_0000_0000;

    localparam logic [1:0] OP_READ  = 2'd0;
    localparam logic [1:0] OP_WRITE = 2'd1;
    localparam logic [1:0] OP_CAS   = 2'd2;

    localparam logic [2:0] RA_OWNER   = 3'd0;
    localparam logic [2:0] RA_EVENTS  = 3'd1;
    localparam logic [2:0] RA_CLKSEL  = 3'd2;
    localparam logic [2:0] RA_ENABLE  = 3'd3;
    localparam logic [2:0] RA_EXTSTAT = 3'd4;

    localparam int EV_RXCFG   = 0;
    localparam int EV_TXCFG   = 1;
    localparam int EV_CURLOCK = 4;
    localparam int EV_ACCEPT  = 5;
    localparam int EV_ANYLOCK = 6;

    localparam logic [7:0]  SRC_MAX      = 8'd12;
    localparam logic [7:0]  RATE_MAX     = 8'd6;
    localparam logic [15:0] CLKSEL_RESET = 16'h020C;

    // Lock state of the selected source, given the per-input lock vector.
    function automatic logic src_locked(input logic [NSRC-1:0] lk,
                                        input logic [7:0] src);
        logic r;
        case (src)
            8'd0, 8'd1, 8'd2, 8'd3:    r = lk[src[1:0]];
            8'd4:                      r = |lk[3:0];
            8'd5:                      r = lk[4];
            8'd6:                      r = lk[5];
            8'd7:                      r = lk[10];
            8'd8, 8'd9, 8'd10, 8'd11:  r = lk[6 + int'(src[1:0])];
            8'd12:                     r = 1'b1;
            default:                   r = 1'b0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/cksn_status.sv
// Lock and slip tracker. Keeps a registered copy of the lock inputs as the
// change reference and sticky slip flags. Assumes inputs are synchronous.
module cksn_status
    import cksn_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] lock_i,
    input  logic [NSRC-1:0] slip_i,
    input  logic            clr_slip_i,
    input  logic [7:0]      src_i,
    output logic [NSRC-1:0] lock_q,
    output logic [NSRC-1:0] slip_q,
    output logic            ev_anylock_o,
    output logic            ev_curlock_o
);
    // Change detection against last cycle's lock state.
    always_comb begin
        ev_anylock_o = |(lock_i ^ lock_q);
        ev_curlock_o = src_locked(lock_i, src_i) != src_locked(lock_q, src_i);
    end

    // Track lock reference; slips set over a concurrent clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= '0;
            slip_q <= '0;
        end else begin
            lock_q <= lock_i;
            slip_q <= (slip_q & ~{NSRC{clr_slip_i}}) | slip_i;
        end
    end
endmodule

// File: rtl/cksn_regs.sv
// Register file: owner word (compare-swap only), clock select, stream
// enable, and read mux with a one-cycle response. Bus reset wins over access.
module cksn_regs
    import cksn_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_reset_i,
    input  logic          req_valid_i,
    input  logic [1:0]    req_op_i,
    input  logic [2:0]    req_addr_i,
    input  logic          req_block_i,
    input  logic [AW-1:0] req_wdata_i,
    input  logic [AW-1:0] req_cmp_i,
    input  logic [DW-1:0] events_i,
    input  logic [DW-1:0] ext_word_i,
    output logic [AW-1:0] owner_q,
    output logic [DW-1:0] enable_q,
    output logic [15:0]   clksel_q,
    output logic          clr_slip_o,
    output logic          accept_o,
    output logic          rsp_valid_o,
    output logic          rsp_ok_o,
    output logic [AW-1:0] rsp_rdata_o
);
    logic          is_rd, is_wr, is_cas, clk_ok, cas_hit, en_wr, addr_ok;
    logic          ok_n;
    logic [AW-1:0] rd_sel;

    // Decode request and acceptance conditions.
    always_comb begin
        is_rd   = req_valid_i && req_op_i == OP_READ;
        is_wr   = req_valid_i && req_op_i == OP_WRITE;
        is_cas  = req_valid_i && req_op_i == OP_CAS;
        clk_ok  = req_wdata_i[7:0] <= SRC_MAX && req_wdata_i[15:8] <= RATE_MAX;
        accept_o = is_wr && req_addr_i == RA_CLKSEL && clk_ok;
        cas_hit = is_cas && req_addr_i == RA_OWNER && req_cmp_i == owner_q && !bus_reset_i;
        en_wr   = is_wr && req_addr_i == RA_ENABLE && !bus_reset_i;
        clr_slip_o = is_rd && req_addr_i == RA_EXTSTAT && !req_block_i;
        addr_ok = req_addr_i <= RA_EXTSTAT;
    end

    // Read data selection.
    always_comb begin
        case (req_addr_i)
            RA_OWNER:   rd_sel = owner_q;
            RA_EVENTS:  rd_sel = {{(AW-DW){1'b0}}, events_i};
            RA_CLKSEL:  rd_sel = {{(AW-16){1'b0}}, clksel_q};
            RA_ENABLE:  rd_sel = {{(AW-DW){1'b0}}, enable_q};
            RA_EXTSTAT: rd_sel = {{(AW-DW){1'b0}}, ext_word_i};
            default:    rd_sel = '0;
        endcase
    end

    // Response acceptance flag.
    always_comb begin
        ok_n = 1'b0;
        if (is_rd)       ok_n = addr_ok;
        else if (is_wr)  ok_n = accept_o || en_wr;
        else if (is_cas) ok_n = cas_hit;
    end

    // Register state updates; bus reset has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q  <= NO_OWNER;
            enable_q <= '0;
            clksel_q <= CLKSEL_RESET;
        end else begin
            if (bus_reset_i) begin
                owner_q  <= NO_OWNER;
                enable_q <= '0;
            end else begin
                if (cas_hit) owner_q  <= req_wdata_i;
                if (en_wr)   enable_q <= req_wdata_i[DW-1:0];
            end
            if (accept_o) clksel_q <= req_wdata_i[15:0];
        end
    end

    // Registered response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_o <= 1'b0;
            rsp_ok_o    <= 1'b0;
            rsp_rdata_o <= '0;
        end else begin
            rsp_valid_o <= req_valid_i;
            rsp_ok_o    <= ok_n;
            rsp_rdata_o <= (is_rd || is_cas) ? rd_sel : '0;
        end
    end
endmodule

// File: rtl/cksn_notify.sv
// Event mask builder and notification issuer. Each cycle with any event
// replaces the event word and, if an owner exists, emits one write request.
module cksn_notify
    import cksn_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_rx_i,
    input  logic          ev_tx_i,
    input  logic          ev_curlock_i,
    input  logic          ev_accept_i,
    input  logic          ev_anylock_i,
    input  logic [AW-1:0] owner_i,
    output logic [DW-1:0] events_q,
    output logic          ntf_valid_o,
    output logic [AW-1:0] ntf_addr_o,
    output logic [DW-1:0] ntf_data_o
);
    logic [DW-1:0] mask;

    // Merge all same-cycle events into one mask.
    always_comb begin
        mask = '0;
        mask[EV_RXCFG]   = ev_rx_i;
        mask[EV_TXCFG]   = ev_tx_i;
        mask[EV_CURLOCK] = ev_curlock_i;
        mask[EV_ACCEPT]  = ev_accept_i;
        mask[EV_ANYLOCK] = ev_anylock_i;
    end

    // Latch the new mask and issue the owner write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            events_q    <= '0;
            ntf_valid_o <= 1'b0;
            ntf_addr_o  <= NO_OWNER;
            ntf_data_o  <= '0;
        end else begin
            ntf_valid_o <= 1'b0;
            if (|mask) begin
                events_q    <= mask;
                ntf_valid_o <= owner_i != NO_OWNER;
                ntf_addr_o  <= owner_i;
                ntf_data_o  <= mask;
            end
        end
    end
endmodule

// File: rtl/clk_event_notifier.sv
// Top: clock lock/slip status bank with owner-directed event notification.
// Assumes all inputs are synchronous to clk; one request per cycle.
module clk_event_notifier
    import cksn_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_reset_i,
    input  logic          req_valid_i,
    input  logic [1:0]    req_op_i,
    input  logic [2:0]    req_addr_i,
    input  logic          req_block_i,
    input  logic [63:0]   req_wdata_i,
    input  logic [63:0]   req_cmp_i,
    output logic          rsp_valid_o,
    output logic          rsp_ok_o,
    output logic [63:0]   rsp_rdata_o,
    input  logic [10:0]   lock_i,
    input  logic [10:0]   slip_i,
    input  logic          rx_cfg_chg_i,
    input  logic          tx_cfg_chg_i,
    output logic          ntf_valid_o,
    output logic [63:0]   ntf_addr_o,
    output logic [31:0]   ntf_data_o,
    output logic          stream_en_o,
    output logic [7:0]    clk_source_o,
    output logic [7:0]    clk_rate_o
);
    logic [AW-1:0]   owner_q;
    logic [DW-1:0]   enable_q, notify_q, ext_word;
    logic [15:0]     clksel_q;
    logic [NSRC-1:0] lock_q, slip_q;
    logic            clr_slip, accept, ev_anylock, ev_curlock;

    // Assemble extended status word from lock and slip fields.
    always_comb begin
        ext_word = '0;
        ext_word[LOCK_LSB +: NSRC] = lock_q;
        ext_word[SLIP_LSB +: NSRC] = slip_q;
    end

    cksn_status u_status (
        .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .slip_i(slip_i),
        .clr_slip_i(clr_slip), .src_i(clksel_q[7:0]),
        .lock_q(lock_q), .slip_q(slip_q),
        .ev_anylock_o(ev_anylock), .ev_curlock_o(ev_curlock)
    );

    cksn_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_reset_i(bus_reset_i),
        .req_valid_i(req_valid_i), .req_op_i(req_op_i), .req_addr_i(req_addr_i),
        .req_block_i(req_block_i), .req_wdata_i(req_wdata_i), .req_cmp_i(req_cmp_i),
        .events_i(notify_q), .ext_word_i(ext_word),
        .owner_q(owner_q), .enable_q(enable_q), .clksel_q(clksel_q),
        .clr_slip_o(clr_slip), .accept_o(accept),
        .rsp_valid_o(rsp_valid_o), .rsp_ok_o(rsp_ok_o), .rsp_rdata_o(rsp_rdata_o)
    );

    cksn_notify u_notify (
        .clk(clk), .rst_n(rst_n),
        .ev_rx_i(rx_cfg_chg_i), .ev_tx_i(tx_cfg_chg_i),
        .ev_curlock_i(ev_curlock), .ev_accept_i(accept), .ev_anylock_i(ev_anylock),
        .owner_i(owner_q), .events_q(notify_q),
        .ntf_valid_o(ntf_valid_o), .ntf_addr_o(ntf_addr_o), .ntf_data_o(ntf_data_o)
    );

    // Output views of the control words.
    always_comb begin
        stream_en_o  = |enable_q;
        clk_source_o = clksel_q[7:0];
        clk_rate_o   = clksel_q[15:8];
    end
endmodule

// File: rtl/cksn_checker.sv
// Property checker for clk_event_notifier, attached by bind.
module cksn_checker
    import cksn_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            bus_reset_i,
    input logic            req_valid_i,
    input logic [1:0]      req_op_i,
    input logic            rsp_valid_o,
    input logic [AW-1:0]   owner_q,
    input logic            stream_en_o,
    input logic [NSRC-1:0] lock_i,
    input logic [NSRC-1:0] lock_q,
    input logic [DW-1:0]   notify_q,
    input logic            ntf_valid_o,
    input logic [NSRC-1:0] slip_q,
    input logic            clr_slip
);
    // R2: every request gets a response on the next cycle
    p_rsp_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> rsp_valid_o);

    // R2: owner holds unless a compare-swap or bus reset occurs
    p_owner_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(req_valid_i && req_op_i == OP_CAS) && !bus_reset_i) |=> $stable(owner_q));

    // R3: bus reset drops owner and streaming
    p_bus_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_i |=> (owner_q == NO_OWNER && !stream_en_o));

    // R4: any lock change sets the lock event bit
    p_lock_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_i != lock_q) |=> notify_q[EV_ANYLOCK]);

    // R8: no notification write without an owner
    p_no_owner_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_q == NO_OWNER) |=> !ntf_valid_o);

    // R7: slip flags stay set unless cleared by a single-word read
    p_slip_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_slip |=> ((slip_q & $past(slip_q)) == $past(slip_q)));
endmodule

bind clk_event_notifier cksn_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_reset_i(bus_reset_i),
    .req_valid_i(req_valid_i), .req_op_i(req_op_i), .rsp_valid_o(rsp_valid_o),
    .owner_q(owner_q), .stream_en_o(stream_en_o), .lock_i(lock_i), .lock_q(lock_q),
    .notify_q(notify_q), .ntf_valid_o(ntf_valid_o), .slip_q(slip_q), .clr_slip(clr_slip)
);

// File: tb/clk_event_notifier_test.sv
// Directed bench for clk_event_notifier: one task per scenario.
module clk_event_notifier_test;
    localparam logic [63:0] NOOWN = 64'hFFFF_0000_0000_0000;
    localparam logic [63:0] OWN_A = 64'hFFC2_0000_0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_reset_i = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [1:0]  req_op_i = 2'd0;
    logic [2:0]  req_addr_i = 3'd0;
    logic        req_block_i = 1'b0;
    logic [63:0] req_wdata_i = '0;
    logic [63:0] req_cmp_i = '0;
    logic        rsp_valid_o, rsp_ok_o;
    logic [63:0] rsp_rdata_o;
    logic [10:0] lock_i = '0;
    logic [10:0] slip_i = '0;
    logic        rx_cfg_chg_i = 1'b0;
    logic        tx_cfg_chg_i = 1'b0;
    logic        ntf_valid_o;
    logic [63:0] ntf_addr_o;
    logic [31:0] ntf_data_o;
    logic        stream_en_o;
    logic [7:0]  clk_source_o, clk_rate_o;

    int errors = 0;
    int checks = 0;
    logic        r_ok;
    logic [63:0] r_data;

    always #2.5 clk = ~clk;

    clk_event_notifier uut (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One request; samples the response just after the capturing edge.
    task automatic xact(input logic [1:0] op, input logic [2:0] addr, input logic blk,
                        input logic [63:0] wd, input logic [63:0] cmp);
        @(negedge clk);
        req_valid_i = 1'b1; req_op_i = op; req_addr_i = addr;
        req_block_i = blk; req_wdata_i = wd; req_cmp_i = cmp;
        @(posedge clk); #1;
        r_ok = rsp_ok_o; r_data = rsp_rdata_o;
        req_valid_i = 1'b0; req_block_i = 1'b0;
    endtask

    task automatic set_lock(input logic [10:0] v);
        @(negedge clk); lock_i = v;
        @(posedge clk); #1;
    endtask

    task automatic t_reset;
        check("R1 rsp_valid", {63'b0, rsp_valid_o}, 64'd0);
        check("R1 ntf_valid", {63'b0, ntf_valid_o}, 64'd0);
        check("R1 stream_en", {63'b0, stream_en_o}, 64'd0);
        check("R1 source", {56'b0, clk_source_o}, 64'd12);
        check("R1 rate", {56'b0, clk_rate_o}, 64'd2);
        xact(2'd0, 3'd0, 1'b0, '0, '0);
        check("R1 owner", r_data, NOOWN);
        xact(2'd0, 3'd1, 1'b0, '0, '0);
        check("R1 events", r_data, 64'd0);
    endtask

    task automatic t_owner;
        xact(2'd1, 3'd0, 1'b0, OWN_A, '0);
        check("R2 plain write refused", {63'b0, r_ok}, 64'd0);
        xact(2'd2, 3'd0, 1'b0, OWN_A, 64'h1234);
        check("R2 cas miss ok", {63'b0, r_ok}, 64'd0);
        check("R2 cas miss old", r_data, NOOWN);
        xact(2'd2, 3'd0, 1'b0, OWN_A, NOOWN);
        check("R2 cas hit ok", {63'b0, r_ok}, 64'd1);
        check("R2 cas hit old", r_data, NOOWN);
        xact(2'd0, 3'd0, 1'b0, '0, '0);
        check("R2 owner after cas", r_data, OWN_A);
    endtask

    task automatic t_lock;
        set_lock(11'h010);
        check("R4 ntf_valid", {63'b0, ntf_valid_o}, 64'd1);
        check("R13 ntf_addr", ntf_addr_o, OWN_A);
        check("R4 ntf_data", {32'b0, ntf_data_o}, 64'h40);
        @(posedge clk); #1;
        check("R4 single pulse", {63'b0, ntf_valid_o}, 64'd0);
    endtask

    task automatic t_curlock;
        xact(2'd1, 3'd2, 1'b0, 64'h0205, '0);
        check("R6 accept ok", {63'b0, r_ok}, 64'd1);
        check("R6 accept event", {32'b0, ntf_data_o}, 64'h20);
        check("R6 source out", {56'b0, clk_source_o}, 64'd5);
        set_lock(11'h000);
        check("R5 current lock bit", {32'b0, ntf_data_o}, 64'h50);
        xact(2'd0, 3'd1, 1'b0, '0, '0);
        check("R4 mask replaced", r_data, 64'h50);
    endtask

    task automatic t_reject;
        xact(2'd1, 3'd2, 1'b0, 64'h0703, '0);
        check("R6 reject ok", {63'b0, r_ok}, 64'd0);
        check("R6 reject no ntf", {63'b0, ntf_valid_o}, 64'd0);
        check("R6 source kept", {56'b0, clk_source_o}, 64'd5);
    endtask

    task automatic t_merge;
        @(negedge clk);
        lock_i = 11'h010; rx_cfg_chg_i = 1'b1;
        req_valid_i = 1'b1; req_op_i = 2'd1; req_addr_i = 3'd2; req_wdata_i = 64'h0405;
        @(posedge clk); #1;
        req_valid_i = 1'b0; rx_cfg_chg_i = 1'b0;
        check("R9 merged valid", {63'b0, ntf_valid_o}, 64'd1);
        check("R9 merged data", {32'b0, ntf_data_o}, 64'h71);
        check("R6 rate out", {56'b0, clk_rate_o}, 64'd4);
        @(posedge clk); #1;
        check("R9 one write only", {63'b0, ntf_valid_o}, 64'd0);
    endtask

    task automatic t_cfg;
        @(negedge clk); tx_cfg_chg_i = 1'b1;
        @(posedge clk); #1; tx_cfg_chg_i = 1'b0;
        check("R12 tx cfg bit", {32'b0, ntf_data_o}, 64'h02);
        @(negedge clk); rx_cfg_chg_i = 1'b1;
        @(posedge clk); #1; rx_cfg_chg_i = 1'b0;
        check("R12 rx cfg bit", {32'b0, ntf_data_o}, 64'h01);
    endtask

    task automatic t_slip;
        @(negedge clk); slip_i = 11'h004;
        @(posedge clk); #1; slip_i = '0;
        check("R7 slip no ntf", {63'b0, ntf_valid_o}, 64'd0);
        xact(2'd0, 3'd4, 1'b0, '0, '0);
        check("R11 status layout", r_data, 64'h0004_0010);
        xact(2'd0, 3'd4, 1'b0, '0, '0);
        check("R7 cleared by single read", r_data, 64'h0000_0010);
        @(negedge clk); slip_i = 11'h400;
        @(posedge clk); #1; slip_i = '0;
        xact(2'd0, 3'd4, 1'b1, '0, '0);
        xact(2'd0, 3'd4, 1'b1, '0, '0);
        check("R7 block read keeps", r_data, 64'h0400_0010);
        xact(2'd0, 3'd4, 1'b0, '0, '0);
        @(negedge clk);
        slip_i = 11'h001; req_valid_i = 1'b1; req_op_i = 2'd0; req_addr_i = 3'd4;
        @(posedge clk); #1;
        slip_i = '0; req_valid_i = 1'b0;
        check("R7 read returns prior", rsp_rdata_o, 64'h0000_0010);
        xact(2'd0, 3'd4, 1'b0, '0, '0);
        check("R7 concurrent slip kept", r_data, 64'h0001_0010);
    endtask

    task automatic t_enable;
        xact(2'd1, 3'd3, 1'b0, 64'd5, '0);
        check("R10 enable on", {63'b0, stream_en_o}, 64'd1);
        xact(2'd1, 3'd3, 1'b0, 64'd0, '0);
        check("R10 enable off", {63'b0, stream_en_o}, 64'd0);
        xact(2'd1, 3'd3, 1'b0, 64'd1, '0);
    endtask

    task automatic t_busreset;
        @(negedge clk); bus_reset_i = 1'b1;
        @(posedge clk); #1; bus_reset_i = 1'b0;
        check("R3 stream off", {63'b0, stream_en_o}, 64'd0);
        xact(2'd0, 3'd0, 1'b0, '0, '0);
        check("R3 owner dropped", r_data, NOOWN);
        @(negedge clk);
        bus_reset_i = 1'b1; req_valid_i = 1'b1; req_op_i = 2'd2; req_addr_i = 3'd0;
        req_wdata_i = OWN_A; req_cmp_i = NOOWN;
        @(posedge clk); #1;
        bus_reset_i = 1'b0; req_valid_i = 1'b0;
        check("R3 cas refused in reset", {63'b0, rsp_ok_o}, 64'd0);
        xact(2'd0, 3'd0, 1'b0, '0, '0);
        check("R3 owner still none", r_data, NOOWN);
    endtask

    task automatic t_noowner;
        set_lock(11'h000);
        check("R8 no write", {63'b0, ntf_valid_o}, 64'd0);
        xact(2'd0, 3'd1, 1'b0, '0, '0);
        check("R8 events updated", r_data, 64'h50);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        t_reset();
        t_owner();
        t_lock();
        t_curlock();
        t_reject();
        t_merge();
        t_cfg();
        t_slip();
        t_enable();
        t_busreset();
        t_noowner();
        repeat (2) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #500000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule